// File: doc/BRIEF.md
# Dual Prescaled PWM Clock Generator

This block turns a master clock into two independent, programmable rate enables for a multi-channel PWM controller. Each rate is a power-of-two prescale followed by an 8-bit linear divide. The outputs are one-cycle enable pulses that the PWM channel counters use to advance.

One 32-bit configuration register sets both rates. The low half drives clock A and the high half drives clock B. Within each half, the divisor sits in bits [7:0] and the prescale exponent sits in bits [11:8]. Bits [15:12] are stored and read back but have no effect. A simple write port loads the register, and a combinational read port returns it.

Any write that changes a half restarts that clock's divider state. The new rate therefore begins from a known phase. A half whose divisor is zero produces no pulses, which includes the all-zero unallocated state.

Top module: `pwm_clkgen_dual`

## Requirements
- R1: Reset (synchronous, active low) clears the configuration register to zero. No enable pulse appears while reset is held or afterwards until a non-zero divisor is written.
- R2: A write with `addr` equal to 0 stores `wdata`, and the read port returns it while `addr` is 0. A write to any other address leaves the register unchanged, and `rdata` is 0 for any other address.
- R3: Clock A uses divisor d = bits [7:0] and exponent e = bits [11:8]. It pulses every d·2^e master cycles. The first pulse is visible d·2^e cycles after the write edge.
- R4: Clock B uses bits [23:16] as divisor and bits [27:24] as exponent, with the same period and first-pulse rule as clock A.
- R5: An enable stays high for exactly one cycle, except when d = 1 and e = 0, where it is high every cycle.
- R6: A clock whose divisor field is zero never pulses, whatever its exponent bits hold. This covers a half that is all zero.
- R7: Exponent values above 10 behave exactly like exponent 10.
- R8: A write that leaves a half unchanged does not disturb that clock's pulse phase.
- R9: A write that changes a half clears that clock's enable at the write edge. It then restarts the clock so that the first pulse comes d·2^e cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (register at 0) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| clka_en | output | 1 | Clock A enable pulse |
| clkb_en | output | 1 | Clock B enable pulse |

## Verification
The divider is tried with configurations that separate the two fields:
- Exponent-only and divisor-only settings show whether prescale and divide multiply rather than add.
- The largest divisor and the largest exponent expose truncation in either counter.
- An exponent of 15 tells saturation apart from wrap-around.
- Zero divisors with non-zero exponents show whether "off" is decided by the divisor or by the whole half.

A mid-run rewrite changes only clock A and separates a per-clock restart from a global one, because clock B must keep its phase while clock A re-phases. Each pattern is judged on the time of the first pulse and on the number of pulses in a window of just over two periods. These two measures catch an off-by-one period and a widened pulse.

// File: rtl/pwm_clkgen_pkg.sv
// Shared field layout for the dual clock generator.
// Assumes each clock owns one CFG_W-wide half of the configuration word.
package pwm_clkgen_pkg;
    localparam int CFG_W   = 16;  // bits per clock configuration half
    localparam int DIV_W   = 8;   // linear divisor width
    localparam int EXP_W   = 4;   // prescale exponent field width
    localparam int EXP_LSB = 8;   // exponent position inside a half
    localparam int MAX_EXP = 10;  // largest honoured exponent
    localparam int NUM_CLK = 2;   // clocks packed in the register
endpackage

// File: rtl/pwm_clkgen_regs.sv
// Configuration register with per-half change detection.
// Assumes a single register at address 0; other addresses read as zero.
module pwm_clkgen_regs #(
    parameter int ADDR_W  = 4,
    parameter int CFG_W   = 16,
    parameter int NUM_CLK = 2,
    localparam int DATA_W = CFG_W * NUM_CLK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [NUM_CLK-1:0] restart,
    output logic [DATA_W-1:0] rdata
);
    logic hit;

    // Decode a write aimed at the configuration register.
    always_comb hit = wr_en && (addr == '0);

    // Hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (hit)
            mode_q <= wdata;
    end

    // Flag each half whose contents a write is about to change.
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_chg
        always_comb restart[g] = hit && (wdata[g*CFG_W +: CFG_W] != mode_q[g*CFG_W +: CFG_W]);
    end

    // Return the register for address 0, zero elsewhere.
    always_comb rdata = (addr == '0) ? mode_q : '0;
endmodule

// File: rtl/pwm_clkgen_div.sv
// One prescale-and-divide channel producing a registered one-cycle enable.
// Assumes restart is asserted on the edge where its configuration changes;
// the new divisor and exponent are then visible from the following cycle.
module pwm_clkgen_div #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 4,
    parameter int MAX_EXP = 10,
    localparam int PRE_W  = MAX_EXP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             en_o
);
    logic [EXP_W-1:0] exp_eff;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] mask;
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] cnt_q;
    logic             tick, last, active;

    // Saturate the exponent and build the prescale tap mask.
    always_comb begin
        exp_eff = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;
        one_sh  = (PRE_W+1)'(1) << exp_eff;
        mask    = one_sh[PRE_W-1:0] - PRE_W'(1);
        tick    = (pre_q & mask) == mask;
        active  = (div_i != '0);
        last    = (cnt_q == div_i - DIV_W'(1));
    end

    // Advance the prescaler, count prescaled ticks, emit the enable.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            pre_q <= '0;
            cnt_q <= '0;
            en_o  <= 1'b0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
            en_o  <= 1'b0;
            if (tick && active) begin
                if (last) begin
                    cnt_q <= '0;
                    en_o  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + DIV_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pwm_clkgen_dual.sv
// Top: configuration register plus two divider channels (A low half, B high half).
// Assumes a single clock domain; enables are registered.
module pwm_clkgen_dual
    import pwm_clkgen_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              clka_en,
    output logic              clkb_en
);
    localparam int DATA_W = CFG_W * NUM_CLK;

    logic [DATA_W-1:0]  mode_q;
    logic [NUM_CLK-1:0] restart;
    logic [NUM_CLK-1:0] en;

    pwm_clkgen_regs #(
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W),
        .NUM_CLK(NUM_CLK)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .mode_q (mode_q),
        .restart(restart),
        .rdata  (rdata)
    );

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
        pwm_clkgen_div #(
            .DIV_W  (DIV_W),
            .EXP_W  (EXP_W),
            .MAX_EXP(MAX_EXP)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart_i(restart[g]),
            .div_i    (mode_q[g*CFG_W +: DIV_W]),
            .exp_i    (mode_q[g*CFG_W + EXP_LSB +: EXP_W]),
            .en_o     (en[g])
        );
    end

    // Map channel enables to named outputs.
    always_comb begin
        clka_en = en[0];
        clkb_en = en[1];
    end
endmodule

// File: rtl/pwm_clkgen_dual_chk.sv
// Property checker for pwm_clkgen_dual, attached by bind.
// Assumes the default 16-bit half layout (divisor [7:0], exponent [11:8]).
module pwm_clkgen_dual_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       mode_q,
    input logic              clka_en,
    input logic              clkb_en
);
    // R1: reset leaves register clear and enables low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && !clka_en && !clkb_en));

    // R2: addressed write stores data
    a_r2_write_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (mode_q == $past(wdata)));

    // R2: other addresses leave register alone
    a_r2_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != '0) |=> $stable(mode_q));

    // R6: zero divisor keeps a clock silent
    a_r6_a_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[7:0] == 8'd0) |-> !clka_en);
    a_r6_b_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[23:16] == 8'd0) |-> !clkb_en);

    // R5: single-cycle pulse unless period is one cycle
    a_r5_a_width: assert property (@(posedge clk) disable iff (!rst_n)
        (clka_en && !(mode_q[7:0] == 8'd1 && mode_q[11:8] == 4'd0)) |=> !clka_en);
    a_r5_b_width: assert property (@(posedge clk) disable iff (!rst_n)
        (clkb_en && !(mode_q[23:16] == 8'd1 && mode_q[27:24] == 4'd0)) |=> !clkb_en);

    // R9: changing a half clears its enable at the write edge
    a_r9_a_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata[15:0] != mode_q[15:0]) |=> !clka_en);
    a_r9_b_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wdata[31:16] != mode_q[31:16]) |=> !clkb_en);
endmodule

bind pwm_clkgen_dual pwm_clkgen_dual_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .mode_q (mode_q),
    .clka_en(clka_en),
    .clkb_en(clkb_en)
);

// File: tb/pwm_clkgen_dual_test.sv
module pwm_clkgen_dual_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        clka_en, clkb_en;

    int total = 0;
    int fails = 0;

    pwm_clkgen_dual #(.ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .clka_en(clka_en), .clkb_en(clkb_en)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] pa;   // expected clock A period, 0 = off
        logic [31:0] pb;   // expected clock B period, 0 = off
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_0001, 32'd1,    32'd0},     // R3 d1 e0, B off (R6)
        '{32'h0000_0305, 32'd40,   32'd0},     // R3 d5 e3
        '{32'h0207_0000, 32'd0,    32'd28},    // R4 d7 e2, A off
        '{32'h0A02_01FF, 32'd510,  32'd2048},  // R3 d255 e1, R4 d2 e10
        '{32'h0F01_0003, 32'd3,    32'd1024},  // R7 e15 acts as e10
        '{32'h0400_0200, 32'd0,    32'd0}      // R6 zero divisor, non-zero exponent
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
    endtask

    initial begin
        #(2_000_000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int first_a, first_b, hits_a, hits_b, win, maxp, bad_a, bad_b, n;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata, 0);
        check("R1 enables in reset", {clka_en, clkb_en}, 0);
        rst_n = 1'b1;
        bad_a = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clka_en || clkb_en) bad_a++;
        end
        check("R1 quiet after reset", bad_a, 0);

        // Vector table: first pulse time and pulse count per clock (R3 R4 R5 R6 R7)
        for (int v = 0; v < 6; v++) begin
            write_reg(4'd0, VECS[v].data);
            check("R2 readback", rdata, VECS[v].data);
            maxp = (VECS[v].pa > VECS[v].pb) ? VECS[v].pa : VECS[v].pb;
            win = (maxp == 0) ? 64 : 2 * maxp + 1;
            first_a = 0; first_b = 0; hits_a = 0; hits_b = 0;
            for (int k = 1; k <= win; k++) begin
                @(negedge clk);
                if (clka_en) begin hits_a++; if (first_a == 0) first_a = k; end
                if (clkb_en) begin hits_b++; if (first_b == 0) first_b = k; end
            end
            check("R3 clock A first pulse", first_a, VECS[v].pa);
            check("R5 clock A pulse count", hits_a, (VECS[v].pa == 0) ? 0 : win / VECS[v].pa);
            check("R4 clock B first pulse", first_b, VECS[v].pb);
            check("R5 clock B pulse count", hits_b, (VECS[v].pb == 0) ? 0 : win / VECS[v].pb);
        end

        // R2: write to another address is ignored
        write_reg(4'd0, 32'h0000_0000);
        write_reg(4'd1, 32'hFFFF_FFFF);
        addr = 4'd1;
        @(negedge clk);
        check("R2 other address reads zero", rdata, 0);
        addr = 4'd0;
        @(negedge clk);
        check("R2 other address write ignored", rdata, 0);
        check("R2 no pulses after ignored write", {clka_en, clkb_en}, 0);

        // R8 / R9: rewrite only clock A mid-run
        write_reg(4'd0, 32'h0103_0004);   // A period 4, B period 6
        bad_a = 0; bad_b = 0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            n = k;
            if (n <= 9) begin
                if (clka_en !== ((n % 4) == 0 && n != 0 && n <= 8)) bad_a++;
            end else begin
                if (clka_en !== (((n - 9) % 2) == 0)) bad_a++;
            end
            if (clkb_en !== ((n % 6) == 0)) bad_b++;
            if (n == 8) begin wr_en = 1'b1; addr = 4'd0; wdata = 32'h0103_0002; end
            if (n == 9) wr_en = 1'b0;
        end
        check("R9 clock A restarted on change", bad_a, 0);
        check("R8 clock B phase kept", bad_b, 0);

        // R1: mid-run reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rdata after mid-run reset", rdata, 0);
        check("R1 enables after mid-run reset", {clka_en, clkb_en}, 0);
        rst_n = 1'b1;
        bad_a = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clka_en || clkb_en) bad_a++;
        end
        check("R1 quiet after mid-run reset", bad_a, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule